// File: doc/BRIEF.md
# Rule 110 Cellular Automaton Array

This block holds a row of 120 one-bit cells and advances them as an elementary one-dimensional cellular automaton under Rule 110. Every cell computes its next value from its left neighbour, itself and its right neighbour, and all cells update together. While running, each clock edge produces one new generation. Positions outside the row count as constant 0, so the two ends do not wrap.

The row is reached through a narrow port. A 5-bit address selects one group of eight cells. The output always shows that group's present state. While the array is paused, a low pulse on the write strobe loads the input byte into the selected group. Reset seeds the row with one live cell at the right end. Stepping starts as soon as the pause input is high after reset.

Top module: `ca110_array`

## Requirements
- R1: A cell's next value is taken from its (left, self, right) triple: 111 gives 0, 110 gives 1, 101 gives 1, 100 gives 0, 011 gives 1, 010 gives 1, 001 gives 1 and 000 gives 0. Left is the cell one place higher in index, and cell 0 is the rightmost.
- R2: After reset every cell is 0 except cell 0, which is 1, so group 0 reads 8'h01 and all other groups read 8'h00.
- R3: While `run_n_halt` is high, each rising clock edge replaces the whole row with its next generation.
- R4: While `run_n_halt` is low and no write is strobed, the row keeps its value on every edge.
- R5: The cell beyond cell 119 and the cell beyond cell 0 both read as 0. The ends do not wrap.
- R6: Group k is cells 8k+7 down to 8k. `rd_byte` bit j shows cell 8k+j for the group on `grp_addr`, and it follows the present state combinationally.
- R7: When `run_n_halt` is low and `wr_strobe_n` is low with `grp_addr` below 15, the clock edge loads `wr_byte` into that group. All other groups keep their values.
- R8: A low `wr_strobe_n` has no effect while `run_n_halt` is high. The row still advances by exactly one generation.
- R9: Addresses 15 to 31 read as 8'h00, and writes to them change no cell.
- R10: Ten generations after reset, group 0 reads 8'h0D, group 1 reads 8'h07 and groups 2 to 14 read 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The row updates on the rising edge. |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| run_n_halt | input | 1 | High lets the row step. Low pauses it and allows writes. |
| wr_strobe_n | input | 1 | Active-low write strobe. It only acts while paused. |
| grp_addr | input | 5 | Selects the 8-cell group for reads and writes. |
| wr_byte | input | 8 | Data loaded into the selected group on a write. |
| rd_byte | output | 8 | Present state of the selected group. |

## Verification
The clocked checks assume that `run_n_halt`, `wr_strobe_n`, `grp_addr` and `wr_byte` settle well before each rising edge. They also assume that the write strobe and the address only move together with the pause input, as a system bus would drive them. The stimulus changes every input only on the falling edge, so each edge sees inputs that have been steady for half a period. It separates write strobes with an idle paused cycle, as the port expects. It keeps the row paused while the internal reset is released, so the first generation is always counted from a known edge.

// File: rtl/ca110_pkg.sv
package ca110_pkg;
  parameter int unsigned GRP_W    = 8;
  parameter int unsigned NUM_GRPS = 15;
  parameter int unsigned ADDR_W   = 5;
  // Lookup code: bit index is {left,self,right}
  parameter logic [7:0]  RULE_CODE = 8'b0110_1110;
endpackage

// File: rtl/ca110_cell.sv
module ca110_cell #(
  parameter logic [7:0] RULE = 8'b0110_1110
) (
  input  logic left_i,
  input  logic self_i,
  input  logic right_i,
  output logic next_o
);
  always_comb begin
    next_o = RULE[{left_i, self_i, right_i}];
  end
endmodule

// File: rtl/ca110_gen.sv
module ca110_gen #(
  parameter int unsigned CELLS = 120,
  parameter logic [7:0]  RULE  = 8'b0110_1110
) (
  input  logic [CELLS-1:0] cur_i,
  output logic [CELLS-1:0] nxt_o
);
  // Zero padding on both ends: no wraparound
  logic [CELLS+1:0] padded;

  always_comb begin
    padded = {1'b0, cur_i, 1'b0};
  end

  genvar i;
  generate
    for (i = 0; i < CELLS; i++) begin : g_cell
      ca110_cell #(.RULE(RULE)) u_cell (
        .left_i (padded[i+2]),
        .self_i (padded[i+1]),
        .right_i(padded[i]),
        .next_o (nxt_o[i])
      );
    end
  endgenerate
endmodule

// File: rtl/ca110_port.sv
module ca110_port #(
  parameter int unsigned GRP_W    = 8,
  parameter int unsigned NUM_GRPS = 15,
  parameter int unsigned ADDR_W   = 5,
  localparam int unsigned CELLS   = GRP_W * NUM_GRPS
) (
  input  logic [CELLS-1:0]  cells_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [GRP_W-1:0]  wdata_i,
  output logic [GRP_W-1:0]  rdata_o,
  output logic [CELLS-1:0]  wr_mask_o,
  output logic [CELLS-1:0]  wr_fill_o,
  output logic              hit_o
);
  logic [NUM_GRPS-1:0] grp_hit;

  genvar b;
  generate
    for (b = 0; b < NUM_GRPS; b++) begin : g_grp
      assign grp_hit[b] = (int'(addr_i) == b);
      assign wr_mask_o[b*GRP_W +: GRP_W] = {GRP_W{grp_hit[b]}};
      assign wr_fill_o[b*GRP_W +: GRP_W] = wdata_i;
    end
  endgenerate

  assign hit_o = |grp_hit;

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_GRPS; k++) begin
      if (grp_hit[k]) rdata_o = cells_i[k*GRP_W +: GRP_W];
    end
  end
endmodule

// File: rtl/ca110_array.sv
module ca110_array
  import ca110_pkg::*;
#(
  parameter int unsigned P_GRP_W    = GRP_W,
  parameter int unsigned P_NUM_GRPS = NUM_GRPS,
  parameter int unsigned P_ADDR_W   = ADDR_W,
  localparam int unsigned CELLS     = P_GRP_W * P_NUM_GRPS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_n_halt,
  input  logic                wr_strobe_n,
  input  logic [P_ADDR_W-1:0] grp_addr,
  input  logic [P_GRP_W-1:0]  wr_byte,
  output logic [P_GRP_W-1:0]  rd_byte
);
  localparam logic [CELLS-1:0] SEED = CELLS'(1);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [CELLS-1:0] cells_q, cells_d, gen_next, wr_mask, wr_fill;
  logic             addr_hit, cells_en;

  ca110_gen #(.CELLS(CELLS), .RULE(RULE_CODE)) u_gen (
    .cur_i(cells_q),
    .nxt_o(gen_next)
  );

  ca110_port #(.GRP_W(P_GRP_W), .NUM_GRPS(P_NUM_GRPS), .ADDR_W(P_ADDR_W)) u_port (
    .cells_i  (cells_q),
    .addr_i   (grp_addr),
    .wdata_i  (wr_byte),
    .rdata_o  (rd_byte),
    .wr_mask_o(wr_mask),
    .wr_fill_o(wr_fill),
    .hit_o    (addr_hit)
  );

  always_comb begin
    cells_en = run_n_halt | (~wr_strobe_n & addr_hit);
    if (run_n_halt) cells_d = gen_next;
    else            cells_d = (cells_q & ~wr_mask) | (wr_fill & wr_mask);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    cells_q <= SEED;
    else if (cells_en) cells_q <= cells_d;
  end

  // R3: a running edge installs the generation computed from the prior row
  a_r3_one_generation: assert property (@(posedge clk) disable iff (!rst_int_n)
    run_n_halt |=> (cells_q == $past(gen_next)));

  // R4: a paused edge without a strobe leaves the row alone
  a_r4_pause_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!run_n_halt && wr_strobe_n) |=> $stable(cells_q));

  // R7: a paused in-range write lands in the addressed group
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!run_n_halt && !wr_strobe_n && int'(grp_addr) < int'(P_NUM_GRPS)) |=>
      (P_GRP_W'(cells_q >> (P_GRP_W * int'($past(grp_addr)))) == $past(wr_byte)));

  // R9: out-of-range paused writes change nothing, and such addresses read zero
  a_r9_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!run_n_halt && int'(grp_addr) >= int'(P_NUM_GRPS)) |=> $stable(cells_q));

  a_r9_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (int'(grp_addr) >= int'(P_NUM_GRPS)) |-> (rd_byte == '0));
endmodule

// File: tb/ca110_array_tb.sv
module ca110_array_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int NG  = 15;
  localparam int N   = W * NG;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         run_n_halt;
  logic         wr_strobe_n;
  logic [4:0]   grp_addr;
  logic [W-1:0] wr_byte;
  logic [W-1:0] rd_byte;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [N-1:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  ca110_array u_dut (
    .clk(clk), .rst_n(rst_n), .run_n_halt(run_n_halt),
    .wr_strobe_n(wr_strobe_n), .grp_addr(grp_addr),
    .wr_byte(wr_byte), .rd_byte(rd_byte)
  );

  function automatic logic [N-1:0] step_model(input logic [N-1:0] s);
    logic [N-1:0] n;
    for (int i = 0; i < N; i++) begin
      int l = (i == N-1) ? 0 : int'(s[i+1]);
      int c = int'(s[i]);
      int r = (i == 0) ? 0 : int'(s[i-1]);
      int idx = l*4 + c*2 + r;
      n[i] = ((110 >> idx) & 1) != 0;
    end
    return n;
  endfunction

  function automatic logic [W-1:0] model_grp(input int a);
    if (a < NG) return model[a*W +: W];
    return '0;
  endfunction

  task automatic chk(input logic [W-1:0] got, input logic [W-1:0] exp, input string req);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  // One clock: drive at the falling edge, compare before the rising edge, advance the model.
  task automatic cyc(input logic run, input logic wn, input int a, input logic [W-1:0] d,
                     input string req);
    @(negedge clk);
    run_n_halt  = run;
    wr_strobe_n = wn;
    grp_addr    = 5'(a);
    wr_byte     = d;
    #1;
    chk(rd_byte, model_grp(a), req);
    @(posedge clk);
    if (run)                    model = step_model(model);
    else if (!wn && a < NG)     model[a*W +: W] = d;
  endtask

  // Paused read of one group against a fixed value from the requirements
  task automatic expect_grp(input int a, input logic [W-1:0] exp, input string req);
    @(negedge clk);
    run_n_halt  = 1'b0;
    wr_strobe_n = 1'b1;
    grp_addr    = 5'(a);
    #1;
    chk(rd_byte, exp, req);
  endtask

  task automatic write_grp(input int a, input logic [W-1:0] d, input string req);
    cyc(1'b0, 1'b0, a, d, req);
    cyc(1'b0, 1'b1, a, d, req);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; run_n_halt = 1'b0; wr_strobe_n = 1'b1; grp_addr = '0; wr_byte = '0;
    model = N'(1);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R2 seed, R9 high addresses read zero
    expect_grp(0, 8'h01, "R2");
    for (int a = 1; a < NG; a++) expect_grp(a, 8'h00, "R2");
    for (int a = NG; a < 32; a++) expect_grp(a, 8'h00, "R9");

    // R10: ten generations, R1/R3 compared on each clock
    for (int g = 0; g < 10; g++) cyc(1'b1, 1'b1, g % 2, 8'h00, "R3");
    expect_grp(0, 8'h0D, "R10");
    expect_grp(1, 8'h07, "R10");
    for (int a = 2; a < NG; a++) expect_grp(a, 8'h00, "R10");

    // R4: pause holds
    for (int k = 0; k < 6; k++) cyc(1'b0, 1'b1, k % 2, 8'h00, "R4");
    expect_grp(0, 8'h0D, "R4");

    // R1/R3/R6: long run, every group swept in turn
    for (int g = 0; g < 400; g++) cyc(1'b1, 1'b1, g % 32, 8'h00, "R1");

    // R7: block writes while paused
    write_grp(0, 8'h07, "R7");
    write_grp(1, 8'hE6, "R7");
    write_grp(2, 8'hD7, "R7");
    expect_grp(0, 8'h07, "R7");
    expect_grp(1, 8'hE6, "R7");
    expect_grp(2, 8'hD7, "R7");
    for (int a = 0; a < NG; a++) cyc(1'b0, 1'b1, a, 8'h00, "R7");

    // R9: out-of-range write ignored
    write_grp(20, 8'hFF, "R9");
    write_grp(31, 8'hA5, "R9");
    for (int a = 0; a < 32; a++) cyc(1'b0, 1'b1, a, 8'h00, "R9");

    // Release and run from the written pattern
    for (int g = 0; g < 50; g++) cyc(1'b1, 1'b1, g % NG, 8'h00, "R3");

    // R8: strobe while running has no effect
    for (int g = 0; g < 20; g++) cyc(1'b1, 1'b0, 3 + (g % 4), 8'hAA, "R8");
    for (int a = 0; a < NG; a++) cyc(1'b0, 1'b1, a, 8'h00, "R8");

    // R5: no wraparound at either end
    for (int a = 0; a < NG; a++) write_grp(a, 8'h00, "R5");
    write_grp(NG-1, 8'h80, "R5");
    cyc(1'b1, 1'b1, 0, 8'h00, "R5");
    expect_grp(0, 8'h00, "R5");
    expect_grp(NG-1, 8'h80, "R5");
    write_grp(NG-1, 8'h00, "R5");
    write_grp(0, 8'h01, "R5");
    cyc(1'b1, 1'b1, NG-1, 8'h00, "R5");
    expect_grp(NG-1, 8'h00, "R5");
    expect_grp(0, 8'h03, "R5");

    // Fully populated row, long run against the model
    for (int a = 0; a < NG; a++) write_grp(a, 8'(a * 37 + 11), "R7");
    for (int g = 0; g < 300; g++) cyc(1'b1, 1'b1, g % NG, 8'h00, "R1");
    for (int a = 0; a < 32; a++) cyc(1'b0, 1'b1, a, 8'h00, "R6");

    finish_run();
  end
endmodule